// File: doc/BRIEF.md
# Converter Fault Supervisor

This block watches over the protection side of a three-rail power controller: two switching buck rails and one linear rail. Digital comparator flags for overcurrent, undervoltage and overvoltage arrive from the analog front end, are resynchronised to the switching clock, and are turned into per-rail actions. These actions are a pulse-skip command, a force-lower-gate command for the switching rails, a global gate enable and a power-good fault indication. A shutdown latch records faults that must stop the converters.

Overcurrent is handled in two steps. First the rail skips pulses while a qualification window of `OC_QUAL` cycles runs. Only if the flag is still present when the window ends does the latch trip. Undervoltage on any rail trips the latch at once. The one exception is core-rail undervoltage while a voltage-code transition is in progress, which is ignored. Overvoltage on a switching rail clamps that rail's lower gate on for as long as the flag stays up and never latches. The linear rail has no overvoltage action. The latch is cleared by re-enabling the block or by a supply restart. The supply monitor uses separate rising and falling threshold flags, which gives it hysteresis.

Top module: `conv_fault_supervisor`

## Requirements
- R1: Every input flag, including enable and the supply flags, passes through a two-flop synchroniser. An input change that is set up before clock edge k first affects the outputs after edge k+1.
- R2: The supply-ok state sets when the synchronised above-high flag is 1. It clears only when the synchronised below-low flag is 1 and the above-high flag is 0. It holds between the two. `gate_en` is 1 only while supply-ok, enable and a clear latch all hold.
- R3: A rising edge of synchronised enable, or the cycle after supply-ok rises, clears `shut_latch`. This clear overrides any trip in the same cycle.
- R4: When synchronised overcurrent is first seen on a running rail, `skip_cmd` for that rail goes to 1 for exactly `OC_QUAL` (default 8) consecutive cycles.
- R5: If overcurrent is still present in the last cycle of the window, `shut_latch` sets at the end of that cycle. If not, skipping stops and the latch stays clear.
- R6: Synchronised undervoltage on any rail (bit 0 core, bit 1 second switching rail, bit 2 linear rail) sets `shut_latch` at the next edge while running.
- R7: Undervoltage on the core rail (bit 0) is ignored while `vid_busy` is 1. Undervoltage on the other rails is not ignored.
- R8: Overvoltage on switching rail j drives `force_low[j]` to 1 while its synchronised flag is 1. It releases the cycle the flag clears and never sets `shut_latch`.
- R9: While `gate_en` is 0 (enable low, supply down or latch set), `skip_cmd` and `force_low` are all 0.
- R10: `pg_fault` is 1 whenever the block is not running, or a counted undervoltage, an overvoltage or an active skip is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switching clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Chip enable, asynchronous |
| vcc_above_hi | input | 1 | Supply above the rising threshold |
| vcc_below_lo | input | 1 | Supply below the falling threshold |
| vid_busy | input | 1 | Core voltage-code transition in progress |
| oc_flag | input | 3 | Overcurrent flag per rail |
| uv_flag | input | 3 | Undervoltage flag per rail |
| ov_flag | input | 2 | Overvoltage flag per switching rail |
| skip_cmd | output | 3 | Pulse-skip command per rail |
| force_low | output | 2 | Force lower gate on, per switching rail |
| gate_en | output | 1 | Gate drivers allowed to switch |
| shut_latch | output | 1 | Shutdown latch state |
| pg_fault | output | 1 | Pulls power-good low |

## Verification
The checker watches on every cycle that a set latch or a disabled block leaves all skip and force outputs low. It also checks that no skip run exceeds the qualification window, that the latch only rises while the block was running, and that a latched shutdown always shows as a power-good fault. The hysteresis of the supply monitor, the exact window length, and the two ways a long overcurrent can end can only be shown by the bench's scenarios. The same holds for undervoltage masking during a code change and for latch clearing by enable and by supply restart. These scenarios are compared against a cycle-level reference model.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
   localparam int unsigned CFS_SYNC_MIN = 2;
   localparam int unsigned CFS_QUAL_MIN = 2;

   typedef struct packed {
      logic en;
      logic hi;
      logic lo;
      logic vid;
   } cfs_ctl_t;

   function automatic int unsigned cfs_cnt_w(input int unsigned limit);
      return $clog2(limit + 1);
   endfunction
endpackage

// File: rtl/cfs_sync.sv
module cfs_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/cfs_oc_qual.sv
module cfs_oc_qual #(
   parameter int unsigned OC_QUAL = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic oc,
   output logic skip,
   output logic expire
);
   import cfs_pkg::*;
   localparam int unsigned CW = cfs_cnt_w(OC_QUAL);
   localparam logic [CW-1:0] LAST = CW'(OC_QUAL);

   logic [CW-1:0] cnt;
   logic          busy;

   assign busy   = (cnt != '0);
   assign skip   = busy & run;
   assign expire = run & (cnt == LAST) & oc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (!run)           cnt <= '0;
      else if (!busy)          cnt <= oc ? CW'(1) : '0;
      else if (cnt == LAST)    cnt <= '0;
      else                     cnt <= cnt + CW'(1);
   end
endmodule

// File: rtl/cfs_latch_ctl.sv
module cfs_latch_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic s_en,
   input  logic s_hi,
   input  logic s_lo,
   input  logic trip,
   output logic active,
   output logic latched
);
   logic sup_ok, sup_prev, en_prev, restart;

   assign restart = (s_en & ~en_prev) | (sup_ok & ~sup_prev);
   assign active  = sup_ok & s_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sup_ok   <= 1'b0;
         sup_prev <= 1'b0;
         en_prev  <= 1'b0;
         latched  <= 1'b0;
      end else begin
         if (s_hi)      sup_ok <= 1'b1;
         else if (s_lo) sup_ok <= 1'b0;
         sup_prev <= sup_ok;
         en_prev  <= s_en;
         if (restart)                         latched <= 1'b0;
         else if (active & ~latched & trip)   latched <= 1'b1;
      end
   end
endmodule

// File: rtl/conv_fault_supervisor.sv
module conv_fault_supervisor #(
   parameter int unsigned NUM_SW      = 2,
   parameter int unsigned NUM_LIN     = 1,
   parameter int unsigned CORE_IDX    = 0,
   parameter int unsigned OC_QUAL     = 8,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned RAILS      = NUM_SW + NUM_LIN
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              vcc_above_hi,
   input  logic              vcc_below_lo,
   input  logic              vid_busy,
   input  logic [RAILS-1:0]  oc_flag,
   input  logic [RAILS-1:0]  uv_flag,
   input  logic [NUM_SW-1:0] ov_flag,
   output logic [RAILS-1:0]  skip_cmd,
   output logic [NUM_SW-1:0] force_low,
   output logic              gate_en,
   output logic              shut_latch,
   output logic              pg_fault
);
   import cfs_pkg::*;
   localparam int unsigned FW = 2 * RAILS + NUM_SW;

   if (NUM_SW < 1)                 begin : g_bad_sw   $error("NUM_SW must be at least 1"); end
   if (CORE_IDX >= NUM_SW)         begin : g_bad_core $error("CORE_IDX must name a switching rail"); end
   if (OC_QUAL < CFS_QUAL_MIN)     begin : g_bad_qual $error("OC_QUAL too small"); end
   if (SYNC_STAGES < CFS_SYNC_MIN) begin : g_bad_sync $error("SYNC_STAGES too small"); end

   cfs_ctl_t          ctl_raw, ctl_s;
   logic [FW-1:0]     flg_s;
   logic [RAILS-1:0]  s_oc, s_uv, uv_cnt, expire;
   logic [NUM_SW-1:0] s_ov;
   logic              active, run, trip;

   assign ctl_raw = '{en: enable, hi: vcc_above_hi, lo: vcc_below_lo, vid: vid_busy};

   cfs_sync #(.W($bits(cfs_ctl_t)), .STAGES(SYNC_STAGES)) u_sync_ctl (
      .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_s)
   );

   cfs_sync #(.W(FW), .STAGES(SYNC_STAGES)) u_sync_flg (
      .clk(clk), .rst_n(rst_n), .d({ov_flag, uv_flag, oc_flag}), .q(flg_s)
   );

   assign s_oc = flg_s[RAILS-1:0];
   assign s_uv = flg_s[2*RAILS-1:RAILS];
   assign s_ov = flg_s[FW-1:2*RAILS];

   for (genvar r = 0; r < RAILS; r++) begin : g_rail
      if (r == CORE_IDX) begin : g_core
         assign uv_cnt[r] = s_uv[r] & ~ctl_s.vid;
      end else begin : g_other
         assign uv_cnt[r] = s_uv[r];
      end
      cfs_oc_qual #(.OC_QUAL(OC_QUAL)) u_oc (
         .clk(clk), .rst_n(rst_n), .run(run), .oc(s_oc[r]),
         .skip(skip_cmd[r]), .expire(expire[r])
      );
   end

   assign trip = (|uv_cnt) | (|expire);

   cfs_latch_ctl u_latch (
      .clk(clk), .rst_n(rst_n), .s_en(ctl_s.en), .s_hi(ctl_s.hi), .s_lo(ctl_s.lo),
      .trip(trip), .active(active), .latched(shut_latch)
   );

   assign run       = active & ~shut_latch;
   assign gate_en   = run;
   assign force_low = s_ov & {NUM_SW{run}};
   assign pg_fault  = ~run | (|uv_cnt) | (|s_ov) | (|skip_cmd);
endmodule

// File: rtl/cfs_checker.sv
module cfs_checker #(
   parameter int unsigned NUM_SW  = 2,
   parameter int unsigned RAILS   = 3,
   parameter int unsigned OC_QUAL = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [RAILS-1:0]  skip_cmd,
   input logic [NUM_SW-1:0] force_low,
   input logic              gate_en,
   input logic              shut_latch,
   input logic              pg_fault
);
   assert_latch_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      shut_latch |-> (skip_cmd == '0 && force_low == '0));

   assert_gate_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_en |-> (force_low == '0 && skip_cmd == '0));

   assert_trip_while_running_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(shut_latch) |-> $past(gate_en));

   assert_latch_shows_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
      shut_latch |-> pg_fault);

   for (genvar r = 0; r < RAILS; r++) begin : g_len
      int unsigned run_len;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           run_len <= 0;
         else if (skip_cmd[r]) run_len <= run_len + 1;
         else                  run_len <= 0;
      end
      assert_skip_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
         run_len <= OC_QUAL);
   end
endmodule

bind conv_fault_supervisor cfs_checker #(
   .NUM_SW(NUM_SW), .RAILS(RAILS), .OC_QUAL(OC_QUAL)
) u_cfs_checker (
   .clk(clk), .rst_n(rst_n), .skip_cmd(skip_cmd), .force_low(force_low),
   .gate_en(gate_en), .shut_latch(shut_latch), .pg_fault(pg_fault)
);

// File: tb/conv_fault_supervisor_bench.sv
module conv_fault_supervisor_bench;
   localparam int Q = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic enable = 1'b0, vcc_above_hi = 1'b0, vcc_below_lo = 1'b1, vid_busy = 1'b0;
   logic [2:0] oc_flag = '0, uv_flag = '0;
   logic [1:0] ov_flag = '0;
   logic [2:0] skip_cmd;
   logic [1:0] force_low;
   logic gate_en, shut_latch, pg_fault;

   int total = 0, bad = 0;

   always #5 clk = ~clk;

   conv_fault_supervisor u_conv_fault_supervisor (.*);

   // reference model: raw inputs pass through a two-entry history queue
   typedef struct packed { logic en, hi, lo, vid; logic [2:0] oc, uv; logic [1:0] ov; } snap_t;
   snap_t hist[$];
   snap_t s;
   int m_cnt[3];
   bit m_sup, m_sup_p, m_en_p, m_lat;

   function automatic snap_t cur_s();
      return (hist.size() >= 2) ? hist[0] : '0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist = {}; m_sup = 0; m_sup_p = 0; m_en_p = 0; m_lat = 0;
         foreach (m_cnt[i]) m_cnt[i] = 0;
      end else begin
         bit act, rn, trp, rst_ev;
         snap_t x;
         x = cur_s();
         act = m_sup && x.en;
         rn = act && !m_lat;
         trp = (x.uv[1] || x.uv[2] || (x.uv[0] && !x.vid));
         for (int i = 0; i < 3; i++) if (m_cnt[i] == Q && x.oc[i] && rn) trp = 1;
         rst_ev = (x.en && !m_en_p) || (m_sup && !m_sup_p);
         for (int i = 0; i < 3; i++) begin
            if (!rn) m_cnt[i] = 0;
            else if (m_cnt[i] == 0) m_cnt[i] = x.oc[i] ? 1 : 0;
            else if (m_cnt[i] == Q) m_cnt[i] = 0;
            else m_cnt[i]++;
         end
         m_sup_p = m_sup;
         m_en_p = x.en;
         if (x.hi) m_sup = 1; else if (x.lo) m_sup = 0;
         if (rst_ev) m_lat = 0; else if (rn && trp) m_lat = 1;
         hist.push_back('{enable, vcc_above_hi, vcc_below_lo, vid_busy, oc_flag, uv_flag, ov_flag});
         if (hist.size() > 2) void'(hist.pop_front());
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      #2;
      if (rst_n) begin
         bit rn; int e_skip, e_pg;
         s = cur_s();
         rn = m_sup && s.en && !m_lat;
         e_skip = 0;
         for (int i = 0; i < 3; i++) if (m_cnt[i] != 0 && rn) e_skip |= (1 << i);
         e_pg = (!rn || s.uv[1] || s.uv[2] || (s.uv[0] && !s.vid) || s.ov != 0 || e_skip != 0);
         check("R3/R5/R6 model latch", shut_latch, m_lat);
         check("R2 model gate_en", gate_en, rn);
         check("R4 model skip", skip_cmd, e_skip);
         check("R8 model force_low", force_low, rn ? s.ov : 0);
         check("R10 model pg_fault", pg_fault, e_pg);
      end
   end

   task automatic ticks(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #400000;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int cnt;
      ticks(3);
      check("R9 reset gate_en", gate_en, 0);
      check("R10 reset pg_fault", pg_fault, 1);
      check("R3 reset latch", shut_latch, 0);
      rst_n = 1'b1;
      ticks(2);
      enable = 1'b1;
      ticks(5);
      check("R2 no start without high flag", gate_en, 0);
      vcc_below_lo = 1'b0; vcc_above_hi = 1'b1;
      ticks(6);
      check("R2 start after high flag", gate_en, 1);
      vcc_above_hi = 1'b0;
      ticks(6);
      check("R2 hysteresis hold", gate_en, 1);
      check("R10 clean pg", pg_fault, 0);

      // R1 latency via overvoltage
      ov_flag[0] = 1'b1;
      ticks(1);
      check("R1 not yet after one edge", force_low[0], 0);
      ticks(1);
      check("R1 visible after two edges", force_low[0], 1);
      check("R8 force on", force_low, 2'b01);
      check("R10 ov shows fault", pg_fault, 1);
      ticks(4);
      ov_flag[0] = 1'b0;
      ticks(3);
      check("R8 force released", force_low, 0);
      check("R8 no latch", shut_latch, 0);

      // R4/R5 short overcurrent pulse on rail 1
      oc_flag[1] = 1'b1;
      ticks(1);
      oc_flag[1] = 1'b0;
      cnt = 0;
      for (int i = 0; i < 20; i++) begin
         ticks(1);
         if (skip_cmd[1]) cnt++;
      end
      check("R4 skip window length", cnt, Q);
      check("R5 short oc no latch", shut_latch, 0);
      check("R5 resume", gate_en, 1);

      // R5 persistent overcurrent on rail 0
      oc_flag[0] = 1'b1;
      ticks(4);
      check("R4 skipping", skip_cmd[0], 1);
      ticks(12);
      check("R5 persistent oc latch", shut_latch, 1);
      check("R9 latched gate off", gate_en, 0);
      check("R9 latched skip quiet", skip_cmd, 0);
      oc_flag[0] = 1'b0;
      ov_flag[1] = 1'b1;
      ticks(4);
      check("R9 latched force quiet", force_low, 0);
      ov_flag[1] = 1'b0;

      // R3 enable cycle
      enable = 1'b0;
      ticks(4);
      enable = 1'b1;
      ticks(5);
      check("R3 enable clears latch", shut_latch, 0);
      check("R3 running again", gate_en, 1);

      // R7 core undervoltage masked during code change
      vid_busy = 1'b1;
      ticks(3);
      uv_flag[0] = 1'b1;
      ticks(6);
      check("R7 masked core uv", shut_latch, 0);
      vid_busy = 1'b0;
      ticks(4);
      check("R6 core uv after change", shut_latch, 1);
      uv_flag[0] = 1'b0;
      enable = 1'b0; ticks(4); enable = 1'b1; ticks(5);
      check("R3 cleared again", shut_latch, 0);

      // R7 other rail not masked, R6 linear rail
      vid_busy = 1'b1;
      uv_flag[2] = 1'b1;
      ticks(4);
      check("R7 linear uv not masked", shut_latch, 1);
      uv_flag[2] = 1'b0;
      vid_busy = 1'b0;

      // R3 supply restart clears latch
      vcc_below_lo = 1'b1;
      ticks(5);
      check("R2 supply drop", gate_en, 0);
      check("R3 latch still set while down", shut_latch, 1);
      vcc_below_lo = 1'b0; vcc_above_hi = 1'b1;
      ticks(6);
      vcc_above_hi = 1'b0;
      check("R3 supply restart clears", shut_latch, 0);
      check("R2 restarted", gate_en, 1);

      // R6 second switching rail
      uv_flag[1] = 1'b1;
      ticks(4);
      check("R6 rail1 uv latch", shut_latch, 1);
      uv_flag[1] = 1'b0;
      ticks(3);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule